// File: doc/BRIEF.md
# Load/Store Address Generator

This block produces, in one combinational pass, the byte address that a load or store uses and the value the base address register takes afterwards. It takes the current base register value, an immediate, an index/offset register value, an addressing-mode code, an element-size code, a vector-alignment control bit and the two bounds of a circular buffer. It returns the effective address, the next base value with its write-enable, a flag that tells the data path to exchange vector elements, and a flag that reports an alignment violation.

The modes cover plain offset addressing with no base write-back, post-update, pre-update, forward and reverse circular post-update, and reverse linear post-update. Circular wraparound uses a crossing test. When a forward step crosses the upper bound, the buffer length is removed from the result. When a backward step crosses the lower bound, the buffer length is added back. All arithmetic is unsigned modulo 2^AW. The register file write itself happens outside this block, on the clock edge where the write-enable is high.

Top module: `ls_agu`

## Requirements
- R1: Mode 0 gives ea = base + imm and mode 1 gives ea = base + idx. In both modes the write-enable is low and the next base output equals the base input.
- R2: Modes 2 and 3 give ea = base. They write back base + imm (mode 2) or base + idx (mode 3).
- R3: Modes 4 and 5 give ea = base + imm (mode 4) or base + idx (mode 5). They write that same value back.
- R4: Size codes map to element steps as follows: 0 is 2 bytes, 1 is 3, 2 and 3 are 4, 4 is 8, 5 is 6, and 6, 7 and 8 are 8. Any other code is 1 byte.
- R5: Mode 6 gives ea = base and steps the base forward by one element. If base < cend and the stepped value is >= cend, then (cend - cbegin) is subtracted.
- R6: Mode 7 gives ea = base and adds idx. When idx bit AW-1 is 0, the forward rule of R5 applies. When it is 1, the backward rule applies: if base >= cbegin and the result is < cbegin, then (cend - cbegin) is added.
- R7: Mode 8 gives ea = base, writes back base minus one element, and raises the swap flag.
- R8: Mode 9 gives ea = base and writes back base minus one element, folded by the backward rule of R6. It raises the swap flag.
- R9: The misalignment flag is set when ea is not a multiple of the required alignment. Size 0 needs 2-byte alignment. Sizes 2 and 3 need 4-byte alignment. Size 4 needs 8-byte alignment. The packed sizes 1 and 5 and all other codes need no alignment.
- R10: With the vector-alignment bit set, sizes 6, 7 and 8 need 8-byte alignment. With it clear, sizes 6 and 7 need 4-byte alignment and size 8 needs 2-byte alignment.
- R11: Mode codes 10 to 15 give ea = base, write-enable low, next base = base, and no swap.
- R12: All sums and differences wrap modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Active-low reset, gates the embedded checks |
| mode_i | input | 4 | Addressing-mode code |
| size_i | input | 4 | Element-size code |
| vec_align64_i | input | 1 | Require 8-byte alignment for vector sizes |
| base_i | input | AW | Current base register value |
| imm_i | input | AW | Immediate offset |
| idx_i | input | AW | Index/offset register value, two's complement in mode 7 |
| cbegin_i | input | AW | Circular buffer lower bound (inclusive) |
| cend_i | input | AW | Circular buffer upper bound (exclusive) |
| ea_o | output | AW | Effective address |
| nbase_o | output | AW | Next base register value |
| nbase_we_o | output | 1 | Base register write-enable |
| swap_o | output | 1 | Exchange vector elements in the result |
| misalign_o | output | 1 | Effective address violates alignment |

## Verification
The bench targets the fold boundaries. These are a step that lands exactly on cend, a base that already sits at or beyond cend, and a negative index that starts below cbegin. A comparison off by one or with the wrong polarity would fold when it should not, or miss a fold. It also drives a negative XC offset. If the sign bit were ignored, the buffer length would be subtracted instead of added. The 3- and 6-byte packed steps and a base near 2^32 expose a wrong step table or a carry that leaks past the address width. Vector sizes run with the alignment bit both set and clear, which catches a misalignment flag that ignores the control input.

// File: rtl/agu_pkg.sv
package agu_pkg;

  localparam int MODE_W = 4;
  localparam int SIZE_W = 4;
  localparam int STEP_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_IMM       = 4'd0,
    AM_IDX       = 4'd1,
    AM_POST_IMM  = 4'd2,
    AM_POST_IDX  = 4'd3,
    AM_PRE_IMM   = 4'd4,
    AM_PRE_IDX   = 4'd5,
    AM_CIRC_IMM  = 4'd6,
    AM_CIRC_IDX  = 4'd7,
    AM_REV       = 4'd8,
    AM_REV_CIRC  = 4'd9
  } agu_mode_e;

  typedef enum logic [SIZE_W-1:0] {
    SZ_H16    = 4'd0,
    SZ_P24    = 4'd1,
    SZ_W32    = 4'd2,
    SZ_F24    = 4'd3,
    SZ_D64    = 4'd4,
    SZ_P24X2  = 4'd5,
    SZ_W32X2  = 4'd6,
    SZ_F24X2  = 4'd7,
    SZ_H16X4  = 4'd8
  } agu_size_e;

endpackage

// File: rtl/agu_size_dec.sv
module agu_size_dec
  import agu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              vec_align64_i,
  output logic [STEP_W-1:0] step_o,
  output logic [2:0]        align_mask_o
);

  always_comb begin
    step_o       = 4'd1;
    align_mask_o = 3'b000;
    case (size_i)
      SZ_H16:   begin step_o = 4'd2; align_mask_o = 3'b001; end
      SZ_P24:   begin step_o = 4'd3; align_mask_o = 3'b000; end
      SZ_W32,
      SZ_F24:   begin step_o = 4'd4; align_mask_o = 3'b011; end
      SZ_D64:   begin step_o = 4'd8; align_mask_o = 3'b111; end
      SZ_P24X2: begin step_o = 4'd6; align_mask_o = 3'b000; end
      SZ_W32X2,
      SZ_F24X2: begin
        step_o       = 4'd8;
        align_mask_o = vec_align64_i ? 3'b111 : 3'b011;
      end
      SZ_H16X4: begin
        step_o       = 4'd8;
        align_mask_o = vec_align64_i ? 3'b111 : 3'b001;
      end
      default:  begin step_o = 4'd1; align_mask_o = 3'b000; end
    endcase
  end

  // R4: every element step is a whole multiple of its alignment unit
  p_step_fits_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o[2:0] & align_mask_o) == 3'b000);

endmodule

// File: rtl/agu_circ_fold.sv
module agu_circ_fold #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] old_i,
  input  logic [AW-1:0] raw_i,
  input  logic [AW-1:0] cbegin_i,
  input  logic [AW-1:0] cend_i,
  input  logic          fwd_en_i,
  input  logic          bwd_en_i,
  output logic [AW-1:0] folded_o
);

  logic [AW-1:0] span;
  logic          cross_up;
  logic          cross_dn;

  always_comb begin
    span     = cend_i - cbegin_i;
    cross_up = fwd_en_i && (old_i < cend_i) && (raw_i >= cend_i);
    cross_dn = bwd_en_i && (old_i >= cbegin_i) && (raw_i < cbegin_i);
    if (cross_up)      folded_o = raw_i - span;
    else if (cross_dn) folded_o = raw_i + span;
    else               folded_o = raw_i;
  end

  // R5: a forward step no longer than the buffer keeps an in-range pointer in range
  p_fwd_stays_in_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en_i && (cbegin_i < cend_i) && !cend_i[AW-1] &&
     (old_i >= cbegin_i) && (old_i < cend_i) &&
     (raw_i >= old_i) && ((raw_i - old_i) <= span))
    |-> ((folded_o >= cbegin_i) && (folded_o < cend_i)));

  // R8: a backward step no longer than the buffer keeps an in-range pointer in range
  p_bwd_stays_in_buf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bwd_en_i && (cbegin_i < cend_i) && !cend_i[AW-1] &&
     (old_i >= cbegin_i) && (old_i < cend_i) &&
     (raw_i <= old_i) && ((old_i - raw_i) <= span))
    |-> ((folded_o >= cbegin_i) && (folded_o < cend_i)));

endmodule

// File: rtl/ls_agu.sv
module ls_agu
  import agu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              vec_align64_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     imm_i,
  input  logic [AW-1:0]     idx_i,
  input  logic [AW-1:0]     cbegin_i,
  input  logic [AW-1:0]     cend_i,
  output logic [AW-1:0]     ea_o,
  output logic [AW-1:0]     nbase_o,
  output logic              nbase_we_o,
  output logic              swap_o,
  output logic              misalign_o
);

  logic [STEP_W-1:0] step;
  logic [2:0]        align_mask;
  logic [AW-1:0]     step_ext;
  logic [AW-1:0]     sum_imm;
  logic [AW-1:0]     sum_idx;
  logic [AW-1:0]     base_inc;
  logic [AW-1:0]     base_dec;
  logic [AW-1:0]     raw_next;
  logic [AW-1:0]     folded;
  logic              fold_fwd;
  logic              fold_bwd;
  logic              use_fold;

  agu_size_dec u_size (
    .clk           (clk),
    .rst_n         (rst_n),
    .size_i        (size_i),
    .vec_align64_i (vec_align64_i),
    .step_o        (step),
    .align_mask_o  (align_mask)
  );

  agu_circ_fold #(.AW(AW)) u_fold (
    .clk      (clk),
    .rst_n    (rst_n),
    .old_i    (base_i),
    .raw_i    (raw_next),
    .cbegin_i (cbegin_i),
    .cend_i   (cend_i),
    .fwd_en_i (fold_fwd),
    .bwd_en_i (fold_bwd),
    .folded_o (folded)
  );

  always_comb begin
    step_ext = {{(AW-STEP_W){1'b0}}, step};
    sum_imm  = base_i + imm_i;
    sum_idx  = base_i + idx_i;
    base_inc = base_i + step_ext;
    base_dec = base_i - step_ext;
  end

  always_comb begin
    ea_o       = base_i;
    raw_next   = base_i;
    nbase_we_o = 1'b0;
    swap_o     = 1'b0;
    fold_fwd   = 1'b0;
    fold_bwd   = 1'b0;
    use_fold   = 1'b0;
    case (mode_i)
      AM_IMM:      ea_o = sum_imm;
      AM_IDX:      ea_o = sum_idx;
      AM_POST_IMM: begin raw_next = sum_imm; nbase_we_o = 1'b1; end
      AM_POST_IDX: begin raw_next = sum_idx; nbase_we_o = 1'b1; end
      AM_PRE_IMM:  begin ea_o = sum_imm; raw_next = sum_imm; nbase_we_o = 1'b1; end
      AM_PRE_IDX:  begin ea_o = sum_idx; raw_next = sum_idx; nbase_we_o = 1'b1; end
      AM_CIRC_IMM: begin
        raw_next = base_inc; nbase_we_o = 1'b1;
        fold_fwd = 1'b1; use_fold = 1'b1;
      end
      AM_CIRC_IDX: begin
        raw_next = sum_idx; nbase_we_o = 1'b1;
        fold_fwd = ~idx_i[AW-1];
        fold_bwd = idx_i[AW-1];
        use_fold = 1'b1;
      end
      AM_REV:      begin raw_next = base_dec; nbase_we_o = 1'b1; swap_o = 1'b1; end
      AM_REV_CIRC: begin
        raw_next = base_dec; nbase_we_o = 1'b1; swap_o = 1'b1;
        fold_bwd = 1'b1; use_fold = 1'b1;
      end
      default: ;
    endcase
    nbase_o    = use_fold ? folded : raw_next;
    misalign_o = |(ea_o[2:0] & align_mask);
  end

  // R1: plain offset modes never write the base back
  p_no_wb_plain_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == AM_IMM) || (mode_i == AM_IDX)) |-> (!nbase_we_o && nbase_o == base_i));

  // R2: every post-update style mode addresses at the unmodified base
  p_post_ea_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == AM_POST_IMM) || (mode_i == AM_POST_IDX) || (mode_i == AM_CIRC_IMM) ||
     (mode_i == AM_CIRC_IDX) || (mode_i == AM_REV) || (mode_i == AM_REV_CIRC))
    |-> (ea_o == base_i && nbase_we_o));

  // R3: pre-update writes back exactly the address it used
  p_pre_wb_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == AM_PRE_IMM) || (mode_i == AM_PRE_IDX)) |-> (nbase_we_o && nbase_o == ea_o));

  // R7: a swap only comes with a base write and an unmodified address
  p_swap_post_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swap_o |-> (nbase_we_o && ea_o == base_i));

  // R9: word-sized accesses reported aligned really sit on a 4-byte boundary
  p_word_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (((size_i == SZ_W32) || (size_i == SZ_F24)) && !misalign_o) |-> (ea_o[1:0] == 2'b00));

  // R10: with 64-bit vector alignment requested, accepted vector addresses are 8-byte aligned
  p_vec_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_align64_i && !misalign_o &&
     ((size_i == SZ_W32X2) || (size_i == SZ_F24X2) || (size_i == SZ_H16X4)))
    |-> (ea_o[2:0] == 3'b000));

  // R11: unassigned mode codes leave the base untouched
  p_undef_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i > 4'd9) |-> (!nbase_we_o && !swap_o && ea_o == base_i && nbase_o == base_i));

endmodule

// File: tb/ls_agu_tb.sv
module ls_agu_tb;

  localparam int AW = 32;

  typedef struct packed {
    logic [3:0]    mode;
    logic [3:0]    size;
    logic          va;
    logic [AW-1:0] base;
    logic [AW-1:0] imm;
    logic [AW-1:0] idx;
    logic [AW-1:0] cb;
    logic [AW-1:0] ce;
  } vec_t;

  typedef struct packed {
    logic [AW-1:0] ea;
    logic [AW-1:0] nb;
    logic          we;
    logic          sw;
    logic          mis;
  } res_t;

  localparam int NV = 16;
  localparam vec_t VECS [0:NV-1] = '{
    '{4'd0, 4'd2, 1'b0, 32'h0000_1000, 32'h0000_0010, 32'h0000_0000, 32'h0, 32'h0},
    '{4'd1, 4'd0, 1'b0, 32'h0000_2000, 32'h0000_0000, 32'h0000_0003, 32'h0, 32'h0},
    '{4'd2, 4'd4, 1'b0, 32'h0000_3000, 32'h0000_0020, 32'h0000_0000, 32'h0, 32'h0},
    '{4'd3, 4'd2, 1'b0, 32'h0000_3004, 32'h0000_0000, 32'hFFFF_FFF8, 32'h0, 32'h0},
    '{4'd4, 4'd3, 1'b0, 32'h0000_4000, 32'h0000_0006, 32'h0000_0000, 32'h0, 32'h0},
    '{4'd5, 4'd8, 1'b1, 32'h0000_4000, 32'h0000_0000, 32'h0000_0008, 32'h0, 32'h0},
    '{4'd6, 4'd2, 1'b0, 32'h0000_100C, 32'h0, 32'h0, 32'h0000_1000, 32'h0000_1010},
    '{4'd6, 4'd0, 1'b0, 32'h0000_1008, 32'h0, 32'h0, 32'h0000_1000, 32'h0000_1010},
    '{4'd7, 4'd2, 1'b0, 32'h0000_1008, 32'h0, 32'h0000_000C, 32'h0000_1000, 32'h0000_1010},
    '{4'd7, 4'd2, 1'b0, 32'h0000_1000, 32'h0, 32'hFFFF_FFFC, 32'h0000_1000, 32'h0000_1010},
    '{4'd8, 4'd5, 1'b0, 32'h0000_2000, 32'h0, 32'h0, 32'h0, 32'h0},
    '{4'd9, 4'd4, 1'b0, 32'h0000_1000, 32'h0, 32'h0, 32'h0000_1000, 32'h0000_1020},
    '{4'd9, 4'd1, 1'b0, 32'h0000_1009, 32'h0, 32'h0, 32'h0000_1000, 32'h0000_1020},
    '{4'd2, 4'd6, 1'b0, 32'hFFFF_FFFC, 32'h0000_0008, 32'h0, 32'h0, 32'h0},
    '{4'd13, 4'd2, 1'b0, 32'h0000_5555, 32'h0000_0100, 32'h0000_0200, 32'h0, 32'h0},
    '{4'd6, 4'd12, 1'b0, 32'h0000_100F, 32'h0, 32'h0, 32'h0000_1000, 32'h0000_1010}
  };

  logic          clk;
  logic          rst_n;
  logic [3:0]    mode_i;
  logic [3:0]    size_i;
  logic          vec_align64_i;
  logic [AW-1:0] base_i, imm_i, idx_i, cbegin_i, cend_i;
  logic [AW-1:0] ea_o, nbase_o;
  logic          nbase_we_o, swap_o, misalign_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ls_agu #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .size_i(size_i),
    .vec_align64_i(vec_align64_i), .base_i(base_i), .imm_i(imm_i),
    .idx_i(idx_i), .cbegin_i(cbegin_i), .cend_i(cend_i), .ea_o(ea_o),
    .nbase_o(nbase_o), .nbase_we_o(nbase_we_o), .swap_o(swap_o),
    .misalign_o(misalign_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference model written from the requirements, using 64-bit arithmetic
  function automatic longint unsigned bytes_of(input logic [3:0] s);
    case (s)
      4'd0: return 2;
      4'd1: return 3;
      4'd2, 4'd3: return 4;
      4'd5: return 6;
      4'd4, 4'd6, 4'd7, 4'd8: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic longint unsigned align_of(input logic [3:0] s, input logic va);
    case (s)
      4'd0: return 2;
      4'd2, 4'd3: return 4;
      4'd4: return 8;
      4'd6, 4'd7: return va ? 8 : 4;
      4'd8: return va ? 8 : 2;
      default: return 1;
    endcase
  endfunction

  function automatic res_t model(input vec_t v);
    res_t r;
    longint unsigned m, b, st, n, ln;
    m  = 64'h1_0000_0000;
    b  = v.base;
    st = bytes_of(v.size);
    ln = (v.ce + m - v.cb) % m;
    r.ea = v.base; r.nb = v.base; r.we = 0; r.sw = 0;
    case (v.mode)
      4'd0: r.ea = (b + v.imm) % m;
      4'd1: r.ea = (b + v.idx) % m;
      4'd2: begin r.we = 1; r.nb = (b + v.imm) % m; end
      4'd3: begin r.we = 1; r.nb = (b + v.idx) % m; end
      4'd4: begin r.we = 1; r.ea = (b + v.imm) % m; r.nb = r.ea; end
      4'd5: begin r.we = 1; r.ea = (b + v.idx) % m; r.nb = r.ea; end
      4'd6: begin
        r.we = 1; n = (b + st) % m;
        if (b < v.ce && n >= v.ce) n = (n + m - ln) % m;
        r.nb = n;
      end
      4'd7: begin
        r.we = 1; n = (b + v.idx) % m;
        if (!v.idx[AW-1]) begin
          if (b < v.ce && n >= v.ce) n = (n + m - ln) % m;
        end else begin
          if (b >= v.cb && n < v.cb) n = (n + ln) % m;
        end
        r.nb = n;
      end
      4'd8: begin r.we = 1; r.sw = 1; r.nb = (b + m - st) % m; end
      4'd9: begin
        r.we = 1; r.sw = 1; n = (b + m - st) % m;
        if (b >= v.cb && n < v.cb) n = (n + ln) % m;
        r.nb = n;
      end
      default: ;
    endcase
    r.mis = ((longint'(r.ea) % align_of(v.size, v.va)) != 0);
    return r;
  endfunction

  task automatic drive(input vec_t v);
    @(posedge clk);
    #5;
    mode_i = v.mode; size_i = v.size; vec_align64_i = v.va;
    base_i = v.base; imm_i = v.imm; idx_i = v.idx;
    cbegin_i = v.cb; cend_i = v.ce;
    #5;
  endtask

  task automatic check(input string req, input res_t exp);
    res_t got;
    got = '{ea_o, nbase_o, nbase_we_o, swap_o, misalign_o};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got ea=%h nb=%h we=%b sw=%b mis=%b, expected ea=%h nb=%h we=%b sw=%b mis=%b",
               req, got.ea, got.nb, got.we, got.sw, got.mis,
               exp.ea, exp.nb, exp.we, exp.sw, exp.mis);
    end
  endtask

  task automatic directed(input string req, input vec_t v, input res_t exp);
    drive(v);
    check(req, exp);
  endtask

  initial begin
    rst_n = 1'b0;
    mode_i = 4'd0; size_i = 4'd0; vec_align64_i = 1'b0;
    base_i = '0; imm_i = '0; idx_i = '0; cbegin_i = '0; cend_i = '0;
    repeat (3) @(posedge clk);
    #10;
    check("R1 reset state", '{32'h0, 32'h0, 1'b0, 1'b0, 1'b0});
    @(posedge clk);
    #5 rst_n = 1'b1;

    // Table walk against the model (R1..R12)
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      check($sformatf("R1-R12 vector %0d mode %0d", i, VECS[i].mode), model(VECS[i]));
    end

    // Directed corner cases with hand-worked expectations
    // R5: step lands exactly on cend and folds to cbegin
    directed("R5 fold at cend", '{4'd6, 4'd2, 1'b0, 32'h100C, 32'h0, 32'h0, 32'h1000, 32'h1010},
             '{32'h100C, 32'h1000, 1'b1, 1'b0, 1'b0});
    // R5: base already at cend does not fold
    directed("R5 no fold from cend", '{4'd6, 4'd2, 1'b0, 32'h1010, 32'h0, 32'h0, 32'h1000, 32'h1010},
             '{32'h1010, 32'h1014, 1'b1, 1'b0, 1'b0});
    // R4 R5: packed 3-byte step crosses and folds
    directed("R4 R5 packed step fold", '{4'd6, 4'd1, 1'b0, 32'h100E, 32'h0, 32'h0, 32'h1000, 32'h1010},
             '{32'h100E, 32'h1001, 1'b1, 1'b0, 1'b0});
    // R6: negative index below cbegin wraps upward
    directed("R6 negative fold", '{4'd7, 4'd2, 1'b0, 32'h1000, 32'h0, 32'hFFFF_FFFC, 32'h1000, 32'h1010},
             '{32'h1000, 32'h100C, 1'b1, 1'b0, 1'b0});
    // R6: negative index starting below cbegin does not fold
    directed("R6 negative no fold", '{4'd7, 4'd2, 1'b0, 32'h0FF8, 32'h0, 32'hFFFF_FFFC, 32'h1000, 32'h1010},
             '{32'h0FF8, 32'h0FF4, 1'b1, 1'b0, 1'b0});
    // R6: positive index crosses cend
    directed("R6 positive fold", '{4'd7, 4'd2, 1'b0, 32'h1008, 32'h0, 32'h0000_000C, 32'h1000, 32'h1010},
             '{32'h1008, 32'h1004, 1'b1, 1'b0, 1'b0});
    // R7 R4: reverse linear, 6-byte packed pair
    directed("R7 reverse step", '{4'd8, 4'd5, 1'b0, 32'h2000, 32'h0, 32'h0, 32'h0, 32'h0},
             '{32'h2000, 32'h1FFA, 1'b1, 1'b1, 1'b0});
    // R8: reverse circular fold at cbegin
    directed("R8 reverse fold", '{4'd9, 4'd4, 1'b0, 32'h1000, 32'h0, 32'h0, 32'h1000, 32'h1020},
             '{32'h1000, 32'h1018, 1'b1, 1'b1, 1'b0});
    // R12: post-update wraps past 2^32
    directed("R12 modulo wrap", '{4'd2, 4'd2, 1'b0, 32'hFFFF_FFFC, 32'h8, 32'h0, 32'h0, 32'h0},
             '{32'hFFFF_FFFC, 32'h4, 1'b1, 1'b0, 1'b0});
    // R9: 16-bit access at an odd address
    directed("R9 halfword misalign", '{4'd0, 4'd0, 1'b0, 32'h1001, 32'h0, 32'h0, 32'h0, 32'h0},
             '{32'h1001, 32'h1001, 1'b0, 1'b0, 1'b1});
    // R9: left-justified fraction at a halfword boundary
    directed("R9 fraction misalign", '{4'd0, 4'd3, 1'b0, 32'h1002, 32'h0, 32'h0, 32'h0, 32'h0},
             '{32'h1002, 32'h1002, 1'b0, 1'b0, 1'b1});
    // R9: packed 24-bit needs no alignment
    directed("R9 packed no align", '{4'd0, 4'd1, 1'b0, 32'h1001, 32'h0, 32'h0, 32'h0, 32'h0},
             '{32'h1001, 32'h1001, 1'b0, 1'b0, 1'b0});
    // R10: vector pair at word boundary, control set then clear
    directed("R10 vector align set", '{4'd0, 4'd6, 1'b1, 32'h1004, 32'h0, 32'h0, 32'h0, 32'h0},
             '{32'h1004, 32'h1004, 1'b0, 1'b0, 1'b1});
    directed("R10 vector align clear", '{4'd0, 4'd6, 1'b0, 32'h1004, 32'h0, 32'h0, 32'h0, 32'h0},
             '{32'h1004, 32'h1004, 1'b0, 1'b0, 1'b0});
    // R11: unassigned mode code leaves everything alone
    directed("R11 undefined mode", '{4'd15, 4'd2, 1'b0, 32'h0000_0040, 32'h10, 32'h20, 32'h0, 32'h0},
             '{32'h40, 32'h40, 1'b0, 1'b0, 1'b0});
    // R3: pre-update with immediate
    directed("R3 pre-update", '{4'd4, 4'd2, 1'b0, 32'h3000, 32'h0000_0004, 32'h0, 32'h0, 32'h0},
             '{32'h3004, 32'h3004, 1'b1, 1'b0, 1'b0});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule